// File: doc/BRIEF.md
# Seconds Real-Time Counter with Coherent Time Reads

This block keeps wall-clock time as a seconds count plus a milliseconds count. Both advance from a slow 32.768 kHz tick. The tick reaches the block as a one-cycle enable, `slow_tick_i`, in the bus clock domain. Software does not read the live counters directly. It reads a bus-side copy, which is refreshed once per eight-tick frame. A busy flag is raised during the tick interval in which that refresh happens. Software must keep its time and alarm writes out of that window.

To read a coherent time pair, software reads milliseconds first. That same read latches the bus-side seconds into a shadow register, and a later read of the shadow returns seconds that belong to the sampled milliseconds. A seconds alarm compare, a countdown event input, a sticky write-one-to-clear status register and a mask register together drive an active-high level interrupt.

Register map (byte offsets, 8-bit address): busy 0x004, seconds 0x008, shadow seconds 0x00C, milliseconds 0x010, alarm compare 0x014, interrupt mask 0x020, interrupt status 0x024. Any other offset reads as zero.

Top module: `rtc_sec_shadow`

## Requirements
- R1: After reset, every register reads zero, busy bit 0 reads 0 and `irq_o` is low.
- R2: Offset 0x004 bit 0 reads 1 for the tick interval that follows every eighth slow tick minus one (ticks 7, 15, 23 … after reset) and reads 0 in all other intervals.
- R3: Each slow tick adds 1000 to a phase accumulator. When the accumulator reaches TICK_HZ, TICK_HZ is subtracted and milliseconds advance by one. When milliseconds pass 999, they return to 0 and seconds advance by one.
- R4: The seconds (0x008) and milliseconds (0x010) registers show the live counts as they stood just before the tick that ends each busy interval. Between those ticks they do not change.
- R5: A read of 0x010 copies the current bus-side seconds into the shadow register (0x00C). The shadow changes at no other time.
- R6: While busy reads 1, a write to seconds or to the alarm compare is ignored and the stored value is unchanged. While busy reads 0, such a write is stored, and seconds read back the written value on the next cycle.
- R7: An alarm compare of zero never raises a status bit. On a slow tick where the live seconds equal a nonzero compare value, status bit 0 is set.
- R8: A one-cycle pulse on `cdn_event_i` sets status bit 1.
- R9: Writing the status register clears each bit written as 1 and leaves each bit written as 0. Writing all ones clears every bit. Status bits otherwise stay set.
- R10: `irq_o` is high exactly when some status bit has its mask bit set. The mask register at 0x020 uses bit 0 for the alarm and bit 1 for the countdown event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| cdn_event_i | input | 1 | Countdown expiry pulse from outside |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
On every cycle, the assertions check four things: the bus-side time copies change only on a refresh or an accepted load; no load reaches the counter inside the busy window; the shadow moves only after a milliseconds read; and status bits stay set until they are written with a one. Some behaviour can only be shown by the bench scenarios. These are the exact millisecond and second values after a known number of ticks, the wrap from 999 to a new second, the lag of the bus copy behind the live count, the alarm firing at a given second, and the interrupt following the mask.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int ADDR_W = 8;
  localparam int N_IRQ  = 2;
  localparam int IRQ_ALARM = 0;
  localparam int IRQ_CDN   = 1;

  localparam logic [ADDR_W-1:0] OFF_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSEC   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h24;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICK_HZ     = 32768,
  parameter int MS_PER_S    = 1000,
  parameter int COPY_PERIOD = 8,
  parameter int SEC_W       = 32,
  localparam int MS_W  = $clog2(MS_PER_S),
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S) + 1,
  localparam int PH_W  = $clog2(COPY_PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic             busy_o,
  output logic [SEC_W-1:0] sec_live_o,
  output logic [SEC_W-1:0] sec_vis_o,
  output logic [MS_W-1:0]  ms_vis_o
);
  localparam logic [ACC_W-1:0] ACC_ADD = ACC_W'(MS_PER_S);
  localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(TICK_HZ);
  localparam logic [MS_W-1:0]  MS_LAST = MS_W'(MS_PER_S - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(COPY_PERIOD - 1);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [ACC_W-1:0] acc_q, acc_d, acc_sum;
  logic [MS_W-1:0]  ms_q, ms_d, ms_vis_q, ms_vis_d;
  logic [SEC_W-1:0] sec_q, sec_d, sec_vis_q, sec_vis_d;

  assign busy_o = (phase_q == PH_LAST);

  always_comb begin
    phase_d   = phase_q;
    acc_d     = acc_q;
    ms_d      = ms_q;
    sec_d     = sec_q;
    ms_vis_d  = ms_vis_q;
    sec_vis_d = sec_vis_q;
    acc_sum   = acc_q + ACC_ADD;
    if (tick_i) begin
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      if (acc_sum >= ACC_LIM) begin
        acc_d = acc_sum - ACC_LIM;
        if (ms_q == MS_LAST) begin
          ms_d  = '0;
          sec_d = sec_q + 1'b1;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end else begin
        acc_d = acc_sum;
      end
      if (busy_o) begin
        ms_vis_d  = ms_q;
        sec_vis_d = sec_q;
      end
    end
    if (load_i) begin
      sec_d     = load_val_i;
      sec_vis_d = load_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      acc_q     <= '0;
      ms_q      <= '0;
      sec_q     <= '0;
      ms_vis_q  <= '0;
      sec_vis_q <= '0;
    end else begin
      phase_q   <= phase_d;
      acc_q     <= acc_d;
      ms_q      <= ms_d;
      sec_q     <= sec_d;
      ms_vis_q  <= ms_vis_d;
      sec_vis_q <= sec_vis_d;
    end
  end

  assign sec_live_o = sec_q;
  assign sec_vis_o  = sec_vis_q;
  assign ms_vis_o   = ms_vis_q;

  AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST); // R3
  AST_NO_LOAD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o); // R6
  AST_VIS_SEC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_vis_q) |-> $past(busy_o || load_i)); // R4
  AST_VIS_MS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ms_vis_q) |-> $past(busy_o && tick_i)); // R4
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         stat_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, status_d, mask_q, mask_d, clr;

  always_comb begin
    clr      = stat_we_i ? wdata_i : '0;
    status_d = (status_q & ~clr) | set_i;
    mask_d   = mask_we_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_q[i]) && !$past(clr[i])) |-> status_q[i]); // R9
    AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[i]) |-> $past(set_i[i])); // R7
  end
endmodule

// File: rtl/rtc_sec_shadow.sv
module rtc_sec_shadow
  import rtc_sec_pkg::*;
#(
  parameter int TICK_HZ     = 32768,
  parameter int MS_PER_S    = 1000,
  parameter int COPY_PERIOD = 8,
  parameter int DATA_W      = 32,
  localparam int MS_W = $clog2(MS_PER_S)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick_i,
  input  logic              cdn_event_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              busy;
  logic [DATA_W-1:0] sec_live, sec_vis, shadow_q, shadow_d, alarm_q, alarm_d;
  logic [MS_W-1:0]   ms_vis;
  logic              wr_ok, load_sec, alarm_we, ms_rd, stat_we, mask_we, alarm_hit;
  logic [N_IRQ-1:0]  status, mask, irq_set;

  always_comb begin
    wr_ok     = bus_sel_i && bus_wr_i && !busy;
    load_sec  = wr_ok && (bus_addr_i == OFF_SEC);
    alarm_we  = wr_ok && (bus_addr_i == OFF_ALARM);
    stat_we   = bus_sel_i && bus_wr_i && (bus_addr_i == OFF_STAT);
    mask_we   = bus_sel_i && bus_wr_i && (bus_addr_i == OFF_MASK);
    ms_rd     = bus_sel_i && !bus_wr_i && (bus_addr_i == OFF_MSEC);
    alarm_hit = slow_tick_i && (alarm_q != '0) && (sec_live == alarm_q);
    irq_set   = '0;
    irq_set[IRQ_ALARM] = alarm_hit;
    irq_set[IRQ_CDN]   = cdn_event_i;
    shadow_d  = ms_rd ? sec_vis : shadow_q;
    alarm_d   = alarm_we ? bus_wdata_i : alarm_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      shadow_q <= '0;
      alarm_q  <= '0;
    end else begin
      shadow_q <= shadow_d;
      alarm_q  <= alarm_d;
    end
  end

  rtc_timebase #(
    .TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S),
    .COPY_PERIOD(COPY_PERIOD), .SEC_W(DATA_W)
  ) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick_i     (slow_tick_i),
    .load_i     (load_sec),
    .load_val_i (bus_wdata_i),
    .busy_o     (busy),
    .sec_live_o (sec_live),
    .sec_vis_o  (sec_vis),
    .ms_vis_o   (ms_vis)
  );

  rtc_irq_ctrl #(.N(N_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_i     (irq_set),
    .stat_we_i (stat_we),
    .mask_we_i (mask_we),
    .wdata_i   (bus_wdata_i[N_IRQ-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_BUSY:   bus_rdata_o = DATA_W'(busy);
      OFF_SEC:    bus_rdata_o = sec_vis;
      OFF_SHADOW: bus_rdata_o = shadow_q;
      OFF_MSEC:   bus_rdata_o = DATA_W'(ms_vis);
      OFF_ALARM:  bus_rdata_o = alarm_q;
      OFF_MASK:   bus_rdata_o = DATA_W'(mask);
      OFF_STAT:   bus_rdata_o = DATA_W'(status);
      default:    bus_rdata_o = '0;
    endcase
  end

  AST_SHADOW_ONLY_ON_MS_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(shadow_q) |-> $past(ms_rd)); // R5
  AST_ALARM_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(status[IRQ_ALARM]) |-> $past(alarm_q != '0)); // R7
  AST_ALARM_HOLD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(busy) |-> (alarm_q == $past(alarm_q))); // R6
endmodule

// File: tb/rtc_sec_shadow_tb_top.sv
module rtc_sec_shadow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        cdn_event = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int ticks  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rtc_sec_shadow #(.TICK_HZ(2048)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick), .cdn_event_i(cdn_event),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
      ticks++;
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 busy", 8'h04, 0);
    expect_reg("R1 sec", 8'h08, 0);
    expect_reg("R1 shadow", 8'h0C, 0);
    expect_reg("R1 msec", 8'h10, 0);
    expect_reg("R1 alarm", 8'h14, 0);
    expect_reg("R1 status", 8'h24, 0);
    @(negedge clk) check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_busy_window;
    run_ticks(6);
    expect_reg("R2 busy low at tick 6", 8'h04, 0);
    run_ticks(1);
    expect_reg("R2 busy high at tick 7", 8'h04, 1);
    run_ticks(1);
    expect_reg("R2 busy low at tick 8", 8'h04, 0);
    expect_reg("R4 msec after first copy", 8'h10, 3);
  endtask

  task automatic t_count_and_copy;
    run_ticks(2048);
    expect_reg("R3 sec after 2056 ticks", 8'h08, 1);
    expect_reg("R3 msec after 2056 ticks", 8'h10, 3);
    run_ticks(4);
    expect_reg("R4 msec held between copies", 8'h10, 3);
    run_ticks(3);
  endtask

  task automatic t_busy_write_ignored;
    expect_reg("R2 busy before ignored write", 8'h04, 1);
    bus_write(8'h08, 32'h55);
    expect_reg("R6 sec write in busy ignored", 8'h08, 1);
    bus_write(8'h14, 32'h9);
    expect_reg("R6 alarm write in busy ignored", 8'h14, 0);
    run_ticks(1);
    expect_reg("R4 msec after copy", 8'h10, 7);
    expect_reg("R5 shadow after msec read", 8'h0C, 1);
  endtask

  task automatic t_shadow;
    bus_write(8'h08, 32'd5);
    expect_reg("R6 sec write accepted", 8'h08, 5);
    expect_reg("R5 shadow unchanged without msec read", 8'h0C, 1);
    expect_reg("R5 msec read", 8'h10, 7);
    expect_reg("R5 shadow after second msec read", 8'h0C, 5);
  endtask

  task automatic t_alarm;
    bus_write(8'h14, 32'd6);
    expect_reg("R6 alarm write accepted", 8'h14, 6);
    run_ticks(2100);
    expect_reg("R3 sec after msec wrap", 8'h08, 6);
    expect_reg("R3 msec after wrap", 8'h10, 30);
    expect_reg("R7 alarm status set", 8'h24, 1);
    @(negedge clk) check("R10 irq low while masked", 32'(irq), 0);
    bus_write(8'h20, 32'd1);
    @(negedge clk) check("R10 irq high when unmasked", 32'(irq), 1);
    bus_write(8'h24, 32'd1);
    expect_reg("R9 alarm status cleared", 8'h24, 0);
    @(negedge clk) check("R10 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_countdown;
    @(negedge clk) cdn_event = 1'b1;
    @(negedge clk) cdn_event = 1'b0;
    expect_reg("R8 countdown status set", 8'h24, 2);
    @(negedge clk) check("R10 irq low with bit1 masked", 32'(irq), 0);
    bus_write(8'h20, 32'd3);
    @(negedge clk) check("R10 irq high bit1 unmasked", 32'(irq), 1);
    bus_write(8'h24, 32'd1);
    expect_reg("R9 write of 0 keeps bit1", 8'h24, 2);
    bus_write(8'h24, 32'hFFFF_FFFF);
    expect_reg("R9 all ones clears", 8'h24, 0);
    @(negedge clk) check("R10 irq low after clear all", 32'(irq), 0);
  endtask

  task automatic t_alarm_disabled;
    bus_write(8'h14, 32'd0);
    bus_write(8'h08, 32'd0);
    run_ticks(12);
    expect_reg("R7 zero alarm raises nothing", 8'h24, 0);
    @(negedge clk) check("R7 irq stays low", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_busy_window();
    t_count_and_copy();
    t_busy_write_ignored();
    t_shadow();
    t_alarm();
    t_countdown();
    t_alarm_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule